// File: doc/BRIEF.md
# Dual-Range Second-Order Sigma-Delta Modulator

This block turns a requested loop-current word into a single-bit oversampled stream whose long-run density of ones equals the requested current as a fraction of a 0 to 32 mA scale. It accepts words in two formats through one valid/ready port. A normal word is a CODE_W-bit code spanning the 4 to 20 mA range. An alarm word is a (CODE_W+1)-bit code spanning 0 to 32 mA. Both formats have the same LSB weight. A normal code is lifted onto the wide scale by adding a fixed offset worth one eighth of full scale. An alarm code is clamped to its usable window. The resulting level is held until the modulator's next update.

The modulator is a loop of two cascaded integrators. The output bit feeds back the full-scale value into both integrators, which gives a noise transfer of (1 - z^-1)^2. A clock-enable input `ce` sets the update rate, and each update emits one bit marked by `bit_valid`. The input port never applies back-pressure: `in_ready` is high whenever the block is out of reset, and a newer word replaces an older one that has not been used yet. The output stream has no ready signal, so the sink must take every bit that is flagged valid. The synchronous active-low reset stops the modulator and clears its state.

Top module: `sdm_dual_range`

## Requirements
- R1: A clock edge with `rst_n` low makes `in_ready`, `bit_valid` and `bit_out` all 0 in the following cycle. It clears both integrators and sets the held level to zero-scale normal (2^(CODE_W-2), one eighth of full scale). With no word loaded after reset, the stream's ones fraction equals 1/8.
- R2: In normal mode (`in_alarm` = 0) the level is `in_code[CODE_W-1:0]` + 2^(CODE_W-2), and bit `in_code[CODE_W]` is ignored. Over n updates starting from reset, the count of ones satisfies |ones*2^(CODE_W+1) - n*level| <= 4*2^(CODE_W+1).
- R3: In alarm mode (`in_alarm` = 1), a code inside the window from 7*2^(CODE_W-5) to 3*2^(CODE_W-1) is used unchanged as the level, with the same density bound as R2.
- R4: An alarm code below 7*2^(CODE_W-5) is raised to that value, and one above 3*2^(CODE_W-1) is lowered to that value. With the default width these limits are 0x03800 and 0x18000. The held level always lies inside this window.
- R5: `bit_valid` is 1 exactly in the cycle after each edge that samples `ce` high. After an edge with `ce` low, `bit_valid` is 0 and `bit_out` keeps its value.
- R6: A word accepted at an edge is first used by the next update at a later edge. When several words are accepted between updates, the last one is used.
- R7: `in_ready` is 1 from the first edge after reset is released. A word is taken at any edge where `in_valid` and `in_ready` are both 1.
- R8: For every level the clamping allows, both integrators stay within half of their range, so they never wrap. The density bound of R2 holds over long runs at both ends of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word ready (no back-pressure outside reset) |
| in_code | input | CODE_W+1 | Code word; normal mode uses the low CODE_W bits |
| in_alarm | input | 1 | 1 selects the 0–32 mA alarm format |
| ce | input | 1 | Modulator update enable |
| bit_valid | output | 1 | A new stream bit is present |
| bit_out | output | 1 | Modulator output bit |

## Verification
The bench builds the block with CODE_W = 6 and GUARD = 6. This gives a 128-level scale, an offset of 16 and an alarm window of 14 to 96. At that size every normal code (with the ignored top bit toggled) and every alarm code, including both clamped regions, can each be run from reset for hundreds of updates. The density of ones is compared against the arithmetic level. Long runs at the two clamp ends exercise integrator headroom, while the handshake, the replacement of a pending word and idle cycles with `ce` low are checked at the ports.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic {
    RANGE_NORMAL = 1'b0,
    RANGE_ALARM  = 1'b1
  } range_e;

  // Levels on the (CODE_W+1)-bit scale, given the scale width.
  function automatic int unsigned lvl_floor(int unsigned scale_w);
    return 7 << (scale_w - 6);
  endfunction

  function automatic int unsigned lvl_ceil(int unsigned scale_w);
    return 3 << (scale_w - 2);
  endfunction

  function automatic int unsigned lvl_offset(int unsigned scale_w);
    return 1 << (scale_w - 3);
  endfunction

endpackage

// File: rtl/sdm_code_map.sv
module sdm_code_map #(
  parameter int unsigned CODE_W = 16
) (
  input  logic [CODE_W:0] code_i,
  input  logic            alarm_i,
  output logic [CODE_W:0] level_o
);
  import sdm_pkg::*;

  localparam int unsigned SCALE_W = CODE_W + 1;
  localparam logic [CODE_W:0] FLOOR_L = SCALE_W'(lvl_floor(SCALE_W));
  localparam logic [CODE_W:0] CEIL_L  = SCALE_W'(lvl_ceil(SCALE_W));
  localparam logic [CODE_W:0] OFFS_L  = SCALE_W'(lvl_offset(SCALE_W));

  range_e mode;

  always_comb begin
    mode = range_e'(alarm_i);
    unique case (mode)
      RANGE_NORMAL: level_o = {1'b0, code_i[CODE_W-1:0]} + OFFS_L;
      RANGE_ALARM: begin
        if (code_i < FLOOR_L)     level_o = FLOOR_L;
        else if (code_i > CEIL_L) level_o = CEIL_L;
        else                      level_o = code_i;
      end
      default: level_o = OFFS_L;
    endcase
  end

endmodule

// File: rtl/sdm_word_hold.sv
module sdm_word_hold #(
  parameter int unsigned LVL_W = 17,
  parameter logic [LVL_W-1:0] RESET_LVL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] level_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)      level_o <= RESET_LVL;
    else if (take_i) level_o <= level_i;
  end

endmodule

// File: rtl/sdm_loop.sv
module sdm_loop #(
  parameter int unsigned LVL_W = 17,
  parameter int unsigned GUARD = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             valid_o,
  output logic             bit_o
);

  localparam int unsigned AW = LVL_W + GUARD + 1;
  localparam logic signed [AW-1:0] FS_S = AW'(2 ** LVL_W);

  logic signed [AW-1:0] acc1, acc2;
  logic signed [AW-1:0] acc1_nx, acc2_nx, drive, fb;
  logic                 qbit;

  always_comb begin
    qbit    = ~acc2[AW-1];
    fb      = qbit ? FS_S : '0;
    drive   = signed'({{(AW-LVL_W){1'b0}}, level_i});
    acc1_nx = acc1 + drive - fb;
    acc2_nx = acc2 + acc1_nx - fb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc1    <= '0;
      acc2    <= '0;
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
    end else begin
      valid_o <= step_i;
      if (step_i) begin
        acc1  <= acc1_nx;
        acc2  <= acc2_nx;
        bit_o <= qbit;
      end
    end
  end

endmodule

// File: rtl/sdm_dual_range.sv
module sdm_dual_range #(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned GUARD  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CODE_W:0] in_code,
  input  logic            in_alarm,
  input  logic            ce,
  output logic            bit_valid,
  output logic            bit_out
);
  import sdm_pkg::*;

  localparam int unsigned SCALE_W = CODE_W + 1;
  localparam logic [CODE_W:0] ZERO_LVL = SCALE_W'(lvl_offset(SCALE_W));

  logic            rdy_q;
  logic            take;
  logic [CODE_W:0] mapped_level;
  logic [CODE_W:0] held_level;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign take     = in_valid & rdy_q;

  sdm_code_map #(.CODE_W(CODE_W)) u_map (
    .code_i  (in_code),
    .alarm_i (in_alarm),
    .level_o (mapped_level)
  );

  sdm_word_hold #(.LVL_W(SCALE_W), .RESET_LVL(ZERO_LVL)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .level_i (mapped_level),
    .level_o (held_level)
  );

  sdm_loop #(.LVL_W(SCALE_W), .GUARD(GUARD)) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (ce),
    .level_i (held_level),
    .valid_o (bit_valid),
    .bit_o   (bit_out)
  );

endmodule

// File: rtl/sdm_dual_range_chk.sv
module sdm_dual_range_chk #(
  parameter int unsigned CODE_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce,
  input logic            in_ready,
  input logic            bit_valid,
  input logic            bit_out,
  input logic [CODE_W:0] held_level
);
  import sdm_pkg::*;

  localparam int unsigned SCALE_W = CODE_W + 1;
  localparam logic [CODE_W:0] FLOOR_L = SCALE_W'(lvl_floor(SCALE_W));
  localparam logic [CODE_W:0] CEIL_L  = SCALE_W'(lvl_ceil(SCALE_W));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!in_ready && !bit_valid && !bit_out));

  assert_level_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (held_level >= FLOOR_L) && (held_level <= CEIL_L));

  assert_valid_after_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> bit_valid);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (!bit_valid && $stable(bit_out)));

  assert_ready_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

endmodule

module sdm_loop_chk #(
  parameter int unsigned AW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [AW-1:0] acc1,
  input logic signed [AW-1:0] acc2
);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc1[AW-1] == acc1[AW-2]) && (acc2[AW-1] == acc2[AW-2]));

endmodule

bind sdm_dual_range sdm_dual_range_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce         (ce),
  .in_ready   (in_ready),
  .bit_valid  (bit_valid),
  .bit_out    (bit_out),
  .held_level (held_level)
);

bind sdm_loop sdm_loop_chk #(.AW(AW)) u_lchk (
  .clk   (clk),
  .rst_n (rst_n),
  .acc1  (acc1),
  .acc2  (acc2)
);

// File: tb/tb_sdm_dual_range.sv
module tb_sdm_dual_range;

  localparam int CW    = 6;
  localparam int LW    = CW + 1;
  localparam int FS    = 1 << LW;
  localparam int OFFS  = 1 << (CW - 2);
  localparam int LO    = 7 << (CW - 5);
  localparam int HI    = 3 << (CW - 1);
  localparam int TOL   = 4;
  localparam int NRUN  = 384;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [CW:0]   in_code = '0;
  logic          in_alarm = 1'b0;
  logic          ce = 1'b0;
  logic          bit_valid;
  logic          bit_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdm_dual_range #(.CODE_W(CW), .GUARD(6)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_code   (in_code),
    .in_alarm  (in_alarm),
    .ce        (ce),
    .bit_valid (bit_valid),
    .bit_out   (bit_out)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic check_mean(input string req, input int ones, input int n, input int level);
    int diff;
    checks++;
    diff = ones * FS - n * level;
    if (diff < 0) diff = -diff;
    if (diff > TOL * FS) begin
      errors++;
      $display("FAIL %s actual ones %0d expected about %0d (level %0d)",
               req, ones, (n * level) / FS, level);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic [CW:0] code, input logic alarm);
    in_code = code; in_alarm = alarm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input int n, output int ones, output int vcount);
    ones = 0; vcount = 0;
    ce = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bit_valid) begin
        vcount++;
        ones += int'(bit_out);
      end
    end
    ce = 1'b0;
  endtask

  int ones, vc, lvl;
  logic held_bit;

  initial begin
    repeat (2) @(negedge clk);
    // R1: outputs idle while held in reset
    check("R1 ready", int'(in_ready), 0);
    check("R1 valid", int'(bit_valid), 0);
    check("R1 bit", int'(bit_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 ready after reset", int'(in_ready), 1);

    // R1: default level after reset is zero-scale normal
    run(NRUN, ones, vc);
    check_mean("R1 default level", ones, NRUN, OFFS);
    check("R5 valid count", vc, NRUN);

    // R5: idle cycles produce no bits and hold the output
    held_bit = bit_out;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      check("R5 idle valid", int'(bit_valid), 0);
      check("R5 idle bit", int'(bit_out), int'(held_bit));
      @(negedge clk);
    end

    // R2: every normal code, top bit toggled and ignored
    for (int k = 0; k < (1 << CW); k++) begin
      do_reset();
      if (k == 0) check("R7 ready before load", int'(in_ready), 1);
      load({1'(k & 1), CW'(k)}, 1'b0);
      run(NRUN, ones, vc);
      check_mean("R2 normal code", ones, NRUN, k + OFFS);
    end

    // R3 and R4: every alarm code, inside and outside the window
    for (int k = 0; k < FS; k++) begin
      do_reset();
      load(LW'(k), 1'b1);
      run(NRUN, ones, vc);
      lvl = (k < LO) ? LO : ((k > HI) ? HI : k);
      if (k < LO || k > HI) check_mean("R4 alarm clamp", ones, NRUN, lvl);
      else                  check_mean("R3 alarm code", ones, NRUN, lvl);
    end

    // R8: long runs at both ends of the window
    do_reset();
    load('0, 1'b1);
    run(4096, ones, vc);
    check_mean("R8 low end long run", ones, 4096, LO);
    do_reset();
    load('1, 1'b1);
    run(4096, ones, vc);
    check_mean("R8 high end long run", ones, 4096, HI);

    // R6: the last of two words accepted between updates is used
    do_reset();
    load(LW'(0), 1'b0);
    load(LW'(90), 1'b1);
    run(NRUN, ones, vc);
    check_mean("R6 latest word used", ones, NRUN, 90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule